// File: doc/BRIEF.md
# Programmable System Interrupt Router

This block collects up to 64 level-sensitive peripheral interrupt requests and steers each one onto one of seven core priority levels, numbered 7 to 13. Software programs a 4-bit level field for each peripheral, an enable mask and a wakeup enable for each peripheral, all over a small 32-bit word-addressed register bus. A request only counts while it is latched in the raw status register and its enable bit is set. For every level the router drives a request line that is high while at least one enabled, pending peripheral is routed to that level.

When the core services a level, it pulses a service request with the level index. One cycle later the router answers with the lowest-numbered enabled, pending peripheral on that level. If no such peripheral exists, the answer is flagged as spurious and a readable spurious counter advances. A separate wakeup output is raised whenever a pending peripheral has its wakeup enable set, whatever its mask.

Top module: `sys_irq_router`

## Requirements
- R1: After a synchronous reset, all level fields, enable masks, wakeup enables, the status register and the spurious counter are zero, and lvl_req, wake, svc_done, svc_id, svc_spur and bus_rdata are zero.
- R2: Register map by word address: 0 to 7 hold the level fields (source n at word n/8, bits (n mod 8)*4+3 down to (n mod 8)*4); 8 and 9 are the enable masks and 10 and 11 the wakeup enables (source n at word base+n/32, bit n mod 32); 12 and 13 are the status banks in the same layout; 14 is the spurious counter. A write takes effect at the clock edge where bus_wr is high, and a read returns the value held before that edge on bus_rdata after the edge where bus_rd is high; bus_rdata holds otherwise.
- R3: Writes to the status and counter addresses change nothing, and a read of any address above 14 returns 0.
- R4: The status register captures src_req on every clock edge, whatever the masks.
- R5: A source is active when its status bit and enable bit are both 1; lvl_req bit l (level 7+l, l from 0 to 6) is high exactly when some active source has level field value l.
- R6: A source whose level field holds 7 to 15 drives no lvl_req bit, even when active.
- R7: A service request with svc_lvl = l produces, one cycle later, svc_done = 1 with svc_id equal to the lowest-numbered active source whose field is l and svc_spur = 0; with no request svc_done, svc_id and svc_spur are 0.
- R8: When the serviced level has no active source (including svc_lvl = 7), svc_spur = 1 and svc_id = 0 in the answer cycle, and the spurious counter increments by one at the same edge.
- R9: wake is high exactly when some source has its status bit and its wakeup enable bit both set; the enable mask has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 64 | Level-sensitive peripheral requests |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lvl_req | output | 7 | Per-level request, bit l is level 7+l |
| svc_req | input | 1 | Service request pulse |
| svc_lvl | input | 3 | Level index being serviced |
| svc_done | output | 1 | Service answer valid |
| svc_id | output | 6 | Lowest active source on the serviced level |
| svc_spur | output | 1 | No active source was found |
| wake | output | 1 | Wakeup request |

## Verification
A wrong level field or mask bit shows on lvl_req in the cycle right after the status capture that makes the affected source pending, and on svc_id at the next service of that level. A corrupted status bit shows on lvl_req and wake one cycle after the src_req change, and a corrupted spurious counter shows on the next read of word 14. The reference model tracks every register and every expected output each cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int unsigned WORD_W          = 32;
    localparam int unsigned FIELD_W         = 4;
    localparam int unsigned FIELDS_PER_WORD = WORD_W / FIELD_W;
    localparam int unsigned LEVELS          = 7;
    localparam int unsigned LVL_W           = 3;

    typedef logic [FIELD_W-1:0] lvl_field_t;
    typedef logic [WORD_W-1:0]  word_t;

    typedef struct packed {
        logic done;
        logic spur;
    } svc_flags_t;

    function automatic logic routes_to(lvl_field_t f, int unsigned lvl);
        return (f == FIELD_W'(lvl));
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned CNT_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          src_req,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  word_t                       wdata,
    input  logic [CNT_W-1:0]            spur_cnt,
    output word_t                       rdata,
    output logic [NUM_SRC*FIELD_W-1:0]  fields,
    output logic [NUM_SRC-1:0]          mask,
    output logic [NUM_SRC-1:0]          wake_en,
    output logic [NUM_SRC-1:0]          status
);

    localparam int unsigned N_ASG     = NUM_SRC / FIELDS_PER_WORD;
    localparam int unsigned N_BANK    = NUM_SRC / WORD_W;
    localparam int unsigned ASG_BASE  = 0;
    localparam int unsigned MASK_BASE = ASG_BASE + N_ASG;
    localparam int unsigned WAKE_BASE = MASK_BASE + N_BANK;
    localparam int unsigned STAT_BASE = WAKE_BASE + N_BANK;
    localparam int unsigned CNT_ADDR  = STAT_BASE + N_BANK;

    word_t              asg_q  [N_ASG];
    word_t              mask_q [N_BANK];
    word_t              wake_q [N_BANK];
    logic [NUM_SRC-1:0] status_q;
    word_t              rdata_q;
    word_t              rd_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_ASG; k++) asg_q[k] <= '0;
            for (int b = 0; b < N_BANK; b++) begin
                mask_q[b] <= '0;
                wake_q[b] <= '0;
            end
            status_q <= '0;
        end else begin
            status_q <= src_req;
            if (wr_en) begin
                for (int k = 0; k < N_ASG; k++)
                    if (addr == ADDR_W'(ASG_BASE + k)) asg_q[k] <= wdata;
                for (int b = 0; b < N_BANK; b++) begin
                    if (addr == ADDR_W'(MASK_BASE + b)) mask_q[b] <= wdata;
                    if (addr == ADDR_W'(WAKE_BASE + b)) wake_q[b] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rd_next = '0;
        for (int k = 0; k < N_ASG; k++)
            if (addr == ADDR_W'(ASG_BASE + k)) rd_next = asg_q[k];
        for (int b = 0; b < N_BANK; b++) begin
            if (addr == ADDR_W'(MASK_BASE + b)) rd_next = mask_q[b];
            if (addr == ADDR_W'(WAKE_BASE + b)) rd_next = wake_q[b];
            if (addr == ADDR_W'(STAT_BASE + b)) rd_next = status_q[b*WORD_W +: WORD_W];
        end
        if (addr == ADDR_W'(CNT_ADDR)) rd_next = WORD_W'(spur_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

    generate
        for (genvar k = 0; k < N_ASG; k++) begin : g_asg_out
            assign fields[k*WORD_W +: WORD_W] = asg_q[k];
        end
        for (genvar b = 0; b < N_BANK; b++) begin : g_bank_out
            assign mask[b*WORD_W +: WORD_W]    = mask_q[b];
            assign wake_en[b*WORD_W +: WORD_W] = wake_q[b];
        end
    endgenerate

    assign status = status_q;
    assign rdata  = rdata_q;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ($stable(mask) && $stable(wake_en) && $stable(fields))) // R2
        else $error("enable or field state changed without a write");

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rdata)) // R2
        else $error("read data changed without a read");

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned LVL     = 0,
    parameter int unsigned ID_W    = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          active,
    input  logic [NUM_SRC*FIELD_W-1:0]  fields,
    output logic                        hit,
    output logic [ID_W-1:0]             id
);

    always_comb begin
        hit = 1'b0;
        id  = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (active[n] && routes_to(fields[n*FIELD_W +: FIELD_W], LVL)) begin
                hit = 1'b1;
                id  = ID_W'(n);
            end
        end
    end

    AST_PICK_VALID: assert property (@(posedge clk) disable iff (rst)
        hit |-> (active[id] && (fields[id*FIELD_W +: FIELD_W] == FIELD_W'(LVL)))) // R7
        else $error("picked source is not active on this level");

    AST_NO_PICK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |-> !hit) // R5
        else $error("level hit with no active source");

endmodule

// File: rtl/irq_svc_unit.sv
module irq_svc_unit
    import sirq_pkg::*;
#(
    parameter int unsigned ID_W  = 6,
    parameter int unsigned CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    svc_req,
    input  logic [LVL_W-1:0]        svc_lvl,
    input  logic [LEVELS-1:0]       hit,
    input  logic [LEVELS*ID_W-1:0]  ids,
    output logic                    svc_done,
    output logic [ID_W-1:0]         svc_id,
    output logic                    svc_spur,
    output logic [CNT_W-1:0]        spur_cnt
);

    logic            sel_hit;
    logic [ID_W-1:0] sel_id;
    svc_flags_t      flags_q;
    logic [ID_W-1:0] id_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        sel_hit = 1'b0;
        sel_id  = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (svc_lvl == LVL_W'(l)) begin
                sel_hit = hit[l];
                sel_id  = ids[l*ID_W +: ID_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            id_q    <= '0;
            cnt_q   <= '0;
        end else begin
            flags_q.done <= svc_req;
            flags_q.spur <= svc_req && !sel_hit;
            id_q         <= (svc_req && sel_hit) ? sel_id : '0;
            if (svc_req && !sel_hit) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign svc_done = flags_q.done;
    assign svc_spur = flags_q.spur;
    assign svc_id   = id_q;
    assign spur_cnt = cnt_q;

    AST_SPUR_ID_ZERO: assert property (@(posedge clk) disable iff (rst)
        svc_spur |-> (svc_done && (svc_id == '0))) // R8
        else $error("spurious answer carries an identifier");

    AST_SPUR_COUNT: assert property (@(posedge clk) disable iff (rst)
        (svc_done && svc_spur) |-> (spur_cnt == $past(spur_cnt) + CNT_W'(1))) // R8
        else $error("spurious counter did not advance");

    AST_CNT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !svc_spur |-> $stable(spur_cnt)) // R8
        else $error("spurious counter moved without a spurious answer");

endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [6:0]          lvl_req,
    input  logic                svc_req,
    input  logic [2:0]          svc_lvl,
    output logic                svc_done,
    output logic [ID_W-1:0]     svc_id,
    output logic                svc_spur,
    output logic                wake
);

    logic [NUM_SRC*FIELD_W-1:0] fields;
    logic [NUM_SRC-1:0]         mask;
    logic [NUM_SRC-1:0]         wake_en;
    logic [NUM_SRC-1:0]         status;
    logic [NUM_SRC-1:0]         active;
    logic [LEVELS-1:0]          hit;
    logic [LEVELS*ID_W-1:0]     ids;
    logic [CNT_W-1:0]           spur_cnt;

    irq_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .src_req  (src_req),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .spur_cnt (spur_cnt),
        .rdata    (bus_rdata),
        .fields   (fields),
        .mask     (mask),
        .wake_en  (wake_en),
        .status   (status)
    );

    assign active = status & mask;

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_level
            irq_level_pick #(
                .NUM_SRC (NUM_SRC),
                .LVL     (l),
                .ID_W    (ID_W)
            ) u_pick (
                .clk    (clk),
                .rst    (rst),
                .active (active),
                .fields (fields),
                .hit    (hit[l]),
                .id     (ids[l*ID_W +: ID_W])
            );
        end
    endgenerate

    assign lvl_req = hit;
    assign wake    = |(status & wake_en);

    irq_svc_unit #(
        .ID_W  (ID_W),
        .CNT_W (CNT_W)
    ) u_svc (
        .clk      (clk),
        .rst      (rst),
        .svc_req  (svc_req),
        .svc_lvl  (svc_lvl),
        .hit      (hit),
        .ids      (ids),
        .svc_done (svc_done),
        .svc_id   (svc_id),
        .svc_spur (svc_spur),
        .spur_cnt (spur_cnt)
    );

    AST_LVL_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
        (lvl_req != '0) |-> ($past(src_req) != '0)) // R4
        else $error("level request without any captured source");

    AST_SVC_HIT_REQ: assert property (@(posedge clk) disable iff (rst)
        (svc_done && !svc_spur) |-> ($past(lvl_req) != '0)) // R7
        else $error("non-spurious answer while no level was requesting");

endmodule

// File: tb/test_sys_irq_router.sv
module test_sys_irq_router;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src_req;
    logic        bus_wr, bus_rd;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [6:0]  lvl_req;
    logic        svc_req;
    logic [2:0]  svc_lvl;
    logic        svc_done;
    logic [5:0]  svc_id;
    logic        svc_spur;
    logic        wake;

    always #10 clk = ~clk;

    sys_irq_router i_sys_irq_router (
        .clk(clk), .rst(rst), .src_req(src_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl_req(lvl_req),
        .svc_req(svc_req), .svc_lvl(svc_lvl), .svc_done(svc_done),
        .svc_id(svc_id), .svc_spur(svc_spur), .wake(wake)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    // behavioural reference state
    logic [31:0] m_asg  [8];
    logic [31:0] m_mask [2];
    logic [31:0] m_wake [2];
    logic [31:0] m_stat [2];
    logic [15:0] m_cnt;
    logic [31:0] e_rdata;
    logic        e_done, e_spur;
    logic [5:0]  e_id;

    function automatic int fld(int n);
        return int'((m_asg[n/8] >> ((n % 8) * 4)) & 32'hF);
    endfunction

    function automatic bit act(int n);
        return m_stat[n/32][n%32] & m_mask[n/32][n%32];
    endfunction

    function automatic logic [6:0] exp_lvl();
        logic [6:0] r = '0;
        for (int n = 0; n < 64; n++)
            if (act(n) && fld(n) < 7) r[fld(n)] = 1'b1;
        return r;
    endfunction

    function automatic bit exp_wake();
        bit r = 0;
        for (int n = 0; n < 64; n++)
            if (m_stat[n/32][n%32] && m_wake[n/32][n%32]) r = 1;
        return r;
    endfunction

    function automatic logic [31:0] mread(int a);
        if (a < 8)   return m_asg[a];
        if (a < 10)  return m_mask[a-8];
        if (a < 12)  return m_wake[a-10];
        if (a < 14)  return m_stat[a-12];
        if (a == 14) return {16'h0, m_cnt};
        return 32'h0;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] actual, logic [63:0] expected);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, actual, expected, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // reference model, updated on every edge from the values held before it
    always @(posedge clk) begin
        int  lv;
        bit  found;
        int  fid;
        if (rst) begin
            for (int k = 0; k < 8; k++) m_asg[k] = '0;
            for (int b = 0; b < 2; b++) begin
                m_mask[b] = '0; m_wake[b] = '0; m_stat[b] = '0;
            end
            m_cnt = '0; e_rdata = '0; e_done = 0; e_spur = 0; e_id = '0;
        end else begin
            if (bus_rd) e_rdata = mread(int'(bus_addr));
            if (svc_req) begin
                lv = int'(svc_lvl);
                found = 0;
                fid = 0;
                for (int n = 0; n < 64; n++)
                    if (!found && lv < 7 && act(n) && fld(n) == lv) begin
                        found = 1; fid = n;
                    end
                e_done = 1;
                e_spur = !found;
                e_id   = found ? 6'(fid) : 6'd0;
                if (!found) m_cnt = m_cnt + 16'd1;
            end else begin
                e_done = 0; e_spur = 0; e_id = '0;
            end
            if (bus_wr) begin
                if (bus_addr < 8)        m_asg[bus_addr] = bus_wdata;
                else if (bus_addr < 10)  m_mask[bus_addr-8] = bus_wdata;
                else if (bus_addr < 12)  m_wake[bus_addr-10] = bus_wdata;
            end
            m_stat[0] = src_req[31:0];
            m_stat[1] = src_req[63:32];
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(lvl_req === exp_lvl(), "R5 lvl_req", 64'(lvl_req), 64'(exp_lvl()));
            chk(wake === exp_wake(), "R9 wake", 64'(wake), 64'(exp_wake()));
            chk(svc_done === e_done, "R7 svc_done", 64'(svc_done), 64'(e_done));
            chk(svc_id === e_id, "R7 svc_id", 64'(svc_id), 64'(e_id));
            chk(svc_spur === e_spur, "R8 svc_spur", 64'(svc_spur), 64'(e_spur));
            chk(bus_rdata === e_rdata, "R2 bus_rdata", 64'(bus_rdata), 64'(e_rdata));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc);
            finish_run();
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        step();
        d = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic service(input logic [2:0] l, output logic dn, output logic [5:0] id, output logic sp);
        svc_req = 1; svc_lvl = l;
        step();
        dn = svc_done; id = svc_id; sp = svc_spur;
        svc_req = 0;
    endtask

    initial begin
        logic [31:0] rd;
        logic        dn, sp;
        logic [5:0]  id;

        rst = 1; src_req = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0;
        bus_wdata = '0; svc_req = 0; svc_lvl = '0;
        repeat (3) step();
        rst = 0;
        step();

        // R1: reset state
        chk(lvl_req == 7'h0 && wake == 1'b0, "R1 outputs", {lvl_req, wake}, 0);
        chk(svc_done == 0 && svc_id == 0 && svc_spur == 0, "R1 service", {svc_done, svc_id, svc_spur}, 0);
        chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
        bus_read(5'd8, rd);  chk(rd == 0, "R1 mask", rd, 0);
        bus_read(5'd0, rd);  chk(rd == 0, "R1 fields", rd, 0);
        bus_read(5'd14, rd); chk(rd == 0, "R1 counter", rd, 0);

        // R4/R5: all pending, nothing enabled
        src_req = '1;
        step();
        chk(lvl_req == 7'h0, "R5 masked", lvl_req, 0);
        bus_read(5'd12, rd); chk(rd == 32'hFFFF_FFFF, "R4 status", rd, 32'hFFFF_FFFF);

        // level fields
        bus_write(5'd0, 32'h0020_0002);   // src0 -> 2, src5 -> 2
        bus_write(5'd2, 32'h000F_0000);   // src20 -> 15
        bus_write(5'd4, 32'h0000_0070);   // src33 -> 7
        bus_write(5'd5, 32'h0000_0006);   // src40 -> 6
        bus_write(5'd7, 32'h2000_0000);   // src63 -> 2
        bus_write(5'd8, 32'h0010_0221);   // enable 0,5,9,20
        bus_write(5'd9, 32'h8000_0102);   // enable 33,40,63
        chk(lvl_req == 7'b100_0101, "R5 R6 routing", lvl_req, 7'b100_0101);
        bus_read(5'd0, rd); chk(rd == 32'h0020_0002, "R2 readback", rd, 32'h0020_0002);

        // R7: lowest-numbered active source
        service(3'd2, dn, id, sp);
        chk(dn && !sp && id == 0, "R7 first", {dn, sp, id}, {1'b1, 1'b0, 6'd0});
        src_req[0] = 0; step();
        service(3'd2, dn, id, sp);
        chk(dn && !sp && id == 5, "R7 second", {dn, sp, id}, {1'b1, 1'b0, 6'd5});
        src_req[5] = 0; step();
        service(3'd2, dn, id, sp);
        chk(dn && !sp && id == 63, "R7 third", {dn, sp, id}, {1'b1, 1'b0, 6'd63});

        // R8: spurious answers
        service(3'd3, dn, id, sp);
        chk(dn && sp && id == 0, "R8 empty level", {dn, sp, id}, {1'b1, 1'b1, 6'd0});
        bus_read(5'd14, rd); chk(rd == 1, "R8 count one", rd, 1);
        service(3'd7, dn, id, sp);
        chk(dn && sp && id == 0, "R8 bad index", {dn, sp, id}, {1'b1, 1'b1, 6'd0});
        bus_read(5'd14, rd); chk(rd == 2, "R8 count two", rd, 2);

        // R3: read-only and unmapped words
        bus_write(5'd12, 32'h0);
        bus_read(5'd12, rd); chk(rd == 32'hFFFF_FFDE, "R3 status write", rd, 32'hFFFF_FFDE);
        bus_write(5'd14, 32'h55);
        bus_read(5'd14, rd); chk(rd == 2, "R3 counter write", rd, 2);
        bus_read(5'd20, rd); chk(rd == 0, "R3 unmapped", rd, 0);

        // R6: fields 7 and 15 route nowhere
        bus_write(5'd8, 32'h0010_0000);
        bus_write(5'd9, 32'h0000_0002);
        chk(lvl_req == 7'h0, "R6 unrouted", lvl_req, 0);

        // R9: wakeup ignores the mask
        chk(wake == 0, "R9 wake off", wake, 0);
        bus_write(5'd11, 32'h0000_0002);
        chk(wake == 1, "R9 wake on", wake, 1);
        bus_write(5'd9, 32'h0);
        chk(wake == 1, "R9 mask no effect", wake, 1);
        src_req[33] = 0; step();
        chk(wake == 0, "R9 source gone", wake, 0);

        // mixed traffic, checked cycle by cycle against the model
        for (int i = 0; i < 600; i++) begin
            src_req   = {$urandom, $urandom};
            svc_req   = ($urandom % 3) == 0;
            svc_lvl   = 3'($urandom % 8);
            bus_wr    = ($urandom % 4) == 0;
            bus_rd    = ($urandom % 2) == 0;
            bus_addr  = bus_wr ? 5'($urandom % 16) : 5'($urandom % 32);
            bus_wdata = $urandom;
            step();
        end
        bus_wr = 0; bus_rd = 0; svc_req = 0;
        step();
        step();
        finish_run();
    end

endmodule